// File: doc/BRIEF.md
# Configurable Logic Cluster with Shared Controls

This block is a cluster of ten programmable logic cells. All ten cells draw on one common pool of control lines. Each cell holds three parts: a 4-input look-up table set by a 16-bit truth table, a one-bit arithmetic slice on a carry path that runs through the whole cluster, and one register. Every cell gives out its combinational result and its registered result. The last cell of the carry path drives the cluster carry-out.

The shared pool has ten lines:

- two clocks, each with its own enable;
- two asynchronous clears;
- one asynchronous load, with a per-cell load value;
- a synchronous clear;
- a synchronous load;
- an add/subtract select.

Two parameters fix the layout of the cluster. One bit per cell picks which of the two clocks the cell uses, and that choice also fixes which enable applies. A two-bit code per cell picks which asynchronous clear applies, if any. Runtime configuration inputs decide, per cell, three things:

- whether the look-up table takes its fourth input from the neighbouring cell's table output;
- whether the register loads from the neighbouring register, so that the cells form a shift chain;
- whether the cell works as an add/subtract slice.

A synchronous active-high reset clears the registers.

Top module: `lcell_cluster`

## Requirements
- R1: When `rst` is high at a cell's clock edge, the cell's register becomes 0, whatever the state of its enable.
- R2: `comb_out[i]` equals bit `{d,c,b,a}` of the mask `lut_mask[16i+15:16i]`. Here a, b, c and d are `din[4i]`, `din[4i+1]`, `din[4i+2]` and `din[4i+3]`. When `lut_link_en[i]` is 1 and i is not 0, d is replaced by the table output of cell i-1. For cell 0 the link bit has no effect.
- R3: When `arith_en[i]` is 1, let L be the table output of cell i. Let B be `din[4i+1]` when `add_sub` is 1 and its inverse when `add_sub` is 0. Then `comb_out[i]` = L xor B xor cin, and the carry passed on is the majority of L, B and cin. The carry into cell 0 is `carry_in`. A cell with `arith_en[i]` at 0 passes the carry through unchanged. `carry_out` is the carry leaving cell 9.
- R4: A cell whose `CLK_SEL` bit is 0 updates on rising edges of `clk_a`, gated by `ena_a`. A cell whose bit is 1 updates on rising edges of `clk_b`, gated by `ena_b`.
- R5: While a cell's paired enable is low at its clock edge, its register holds its value. `sclr`, `sload` and new data have no effect on it.
- R6: `ACLR_SEL[2i+1:2i]` set to 01 ties cell i to `aclr0`, and set to 10 ties it to `aclr1`. The codes 00 and 11 tie it to neither. A selected clear forces the register to 0 at once, with no clock edge, and overrides every other control.
- R7: When `aload` is high and the cell's selected clear is not, the register takes `aload_data[i]` at once, with no clock edge. With `aload_data[i]` at 1 this presets the register. This load ranks above `rst` and every synchronous control.
- R8: When the enable is high at a clock edge, `sclr` clears the register, and it ranks above `sload`.
- R9: When the enable is high at a clock edge and `sclr` is low, `sload` loads `din[4i+2]`.
- R10: With no synchronous control active, the register captures `comb_out[i]` when `reg_chain_en[i]` is 0. When `reg_chain_en[i]` is 1 it captures the register of cell i-1, and cell 0 captures `shift_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First shared clock |
| clk_b | input | 1 | Second shared clock |
| rst | input | 1 | Synchronous active-high reset |
| ena_a | input | 1 | Enable paired with clk_a |
| ena_b | input | 1 | Enable paired with clk_b |
| aclr0 | input | 1 | First asynchronous clear |
| aclr1 | input | 1 | Second asynchronous clear |
| aload | input | 1 | Asynchronous load/preset |
| aload_data | input | 10 | Per-cell asynchronous load value |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of data input c |
| add_sub | input | 1 | 1 = add, 0 = subtract |
| carry_in | input | 1 | Carry into cell 0 |
| shift_in | input | 1 | Register chain input of cell 0 |
| lut_mask | input | 160 | Truth tables, 16 bits per cell |
| lut_link_en | input | 10 | Per-cell table-chain select |
| reg_chain_en | input | 10 | Per-cell register-chain select |
| arith_en | input | 10 | Per-cell arithmetic mode |
| din | input | 40 | Data inputs, 4 bits per cell |
| comb_out | output | 10 | Per-cell combinational result |
| reg_out | output | 10 | Per-cell registered result |
| carry_out | output | 1 | Carry leaving cell 9 |

## Verification
The bench goes after the edges of the control priority. It raises a clear together with a load, and it holds the enable low while a synchronous clear or load is asserted. A design that ranks these wrongly would leave a register preset where it must be cleared, or let a stopped cell change. It probes the register straight after an asynchronous clear or load, before any clock edge, to catch a design that waits for a clock. It also probes which clear line each cell obeys, since a swapped selection clears the wrong group of cells. Ripple runs of all-ones operands, add/subtract flips from cycle to cycle, and mixes of arithmetic and plain cells catch a design whose carry is inverted, uses the wrong polarity, or does not pass through plain cells. Register shift chains that cross between the two clock groups expose a design that takes the neighbour's value at the wrong edge.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
    localparam int LUT_K = 4;
    localparam int LUT_W = 1 << LUT_K;

    typedef enum logic [1:0] {
        CLR_OFF     = 2'b00,
        CLR_LINE0   = 2'b01,
        CLR_LINE1   = 2'b10,
        CLR_OFF_ALT = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic s;
        logic co;
    } bit_sum_t;

    typedef struct packed {
        logic [LUT_W-1:0] mask;
        logic [LUT_K-1:0] pins;
        logic             link;
        logic             arith;
    } cell_cfg_t;

    function automatic logic lut_eval(input logic [LUT_W-1:0] mask,
                                      input logic [LUT_K-1:0] sel);
        return mask[sel];
    endfunction

    // one-bit add (add=1) or subtract (add=0, second operand inverted)
    function automatic bit_sum_t add_sub_bit(input logic a, input logic b,
                                             input logic cin, input logic add);
        bit_sum_t r;
        logic     bb;
        bb   = add ? b : ~b;
        r.s  = a ^ bb ^ cin;
        r.co = (a & bb) | (a & cin) | (bb & cin);
        return r;
    endfunction
endpackage

// File: rtl/lc_ctrl.sv
`timescale 1ns/1ps
module lc_ctrl #(
    parameter int               N_CELL   = 10,
    parameter logic [N_CELL-1:0]   CLK_SEL  = '0,
    parameter logic [2*N_CELL-1:0] ACLR_SEL = '0
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              ena_a,
    input  logic              ena_b,
    input  logic              aclr0,
    input  logic              aclr1,
    output logic [N_CELL-1:0] cell_clk,
    output logic [N_CELL-1:0] cell_ce,
    output logic [N_CELL-1:0] cell_clr
);
    import lc_pkg::*;

    for (genvar i = 0; i < N_CELL; i++) begin : g_cell
        localparam logic [1:0] SEL = ACLR_SEL[2*i +: 2];
        // clock and enable always travel as a pair
        if (CLK_SEL[i]) begin : g_pair_b
            assign cell_clk[i] = clk_b;
            assign cell_ce[i]  = ena_b;
        end else begin : g_pair_a
            assign cell_clk[i] = clk_a;
            assign cell_ce[i]  = ena_a;
        end
        if (SEL == CLR_LINE0) begin : g_clr0
            assign cell_clr[i] = aclr0;
        end else if (SEL == CLR_LINE1) begin : g_clr1
            assign cell_clr[i] = aclr1;
        end else begin : g_clr_none
            assign cell_clr[i] = 1'b0;
        end
    end
endmodule

// File: rtl/lc_comb.sv
`timescale 1ns/1ps
module lc_comb #(
    parameter int N_CELL = 10,
    localparam int K     = lc_pkg::LUT_K,
    localparam int W     = lc_pkg::LUT_W
) (
    input  logic [N_CELL*W-1:0] lut_mask,
    input  logic [N_CELL*K-1:0] din,
    input  logic [N_CELL-1:0]   lut_link_en,
    input  logic [N_CELL-1:0]   arith_en,
    input  logic                add_sub,
    input  logic                carry_in,
    output logic [N_CELL-1:0]   comb_out,
    output logic                carry_out
);
    import lc_pkg::*;

    localparam logic [N_CELL-1:0] FIRST = N_CELL'(1);

    logic [N_CELL-1:0] lut_o;
    logic [N_CELL-1:0] prev_lut;
    logic [N_CELL-1:0] link_eff;
    logic [N_CELL:0]   cy;

    assign link_eff = lut_link_en & ~FIRST;
    assign prev_lut = {lut_o[N_CELL-2:0], 1'b0};
    assign cy[0]    = carry_in;
    assign carry_out = cy[N_CELL];

    for (genvar i = 0; i < N_CELL; i++) begin : g_cell
        cell_cfg_t        cfg;
        logic [K-1:0]     sel;
        bit_sum_t         r;

        assign cfg.mask  = lut_mask[i*W +: W];
        assign cfg.pins  = din[i*K +: K];
        assign cfg.link  = link_eff[i];
        assign cfg.arith = arith_en[i];

        assign sel      = {cfg.link ? prev_lut[i] : cfg.pins[K-1], cfg.pins[K-2:0]};
        assign lut_o[i] = lut_eval(cfg.mask, sel);
        assign r        = add_sub_bit(lut_o[i], cfg.pins[1], cy[i], add_sub);

        assign comb_out[i] = cfg.arith ? r.s  : lut_o[i];
        assign cy[i+1]     = cfg.arith ? r.co : cy[i];
    end
endmodule

// File: rtl/lc_reg.sv
`timescale 1ns/1ps
module lc_reg (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic clr,
    input  logic aload,
    input  logic aload_val,
    input  logic sclr,
    input  logic sload,
    input  logic sload_val,
    input  logic chain_sel,
    input  logic chain_val,
    input  logic data_val,
    output logic q
);
    logic async_hit;
    logic d_next;

    assign async_hit = clr | aload;
    assign d_next    = chain_sel ? chain_val : data_val;

    always_ff @(posedge clk or posedge async_hit) begin
        if (clr)        q <= 1'b0;
        else if (aload) q <= aload_val;
        else if (rst)   q <= 1'b0;
        else if (ce) begin
            if (sclr)       q <= 1'b0;
            else if (sload) q <= sload_val;
            else            q <= d_next;
        end
    end

    // R6: selected clear forces zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clr |-> (q == 1'b0));

    // R7: async load value visible while held
    p_aload_val_r7: assert property (@(posedge clk) disable iff (rst)
        (aload && !clr) |-> (q == aload_val));

    // R5: no change while paired enable is low
    p_gated_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(ce) && !$past(rst) && !$past(async_hit) && !async_hit) |-> $stable(q));

    // R8: synchronous clear wins at an enabled edge
    p_sclr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(ce) && $past(sclr) && !$past(rst) && !$past(async_hit) && !async_hit)
        |-> (q == 1'b0));

    // R9: synchronous load takes data input c
    p_sload_val_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(ce) && !$past(sclr) && $past(sload) && !$past(rst)
         && !$past(async_hit) && !async_hit) |-> (q == $past(sload_val)));
endmodule

// File: rtl/lcell_cluster.sv
`timescale 1ns/1ps
module lcell_cluster #(
    parameter int                  N_CELL   = 10,
    parameter logic [N_CELL-1:0]   CLK_SEL  = 10'b11111_00000,
    parameter logic [2*N_CELL-1:0] ACLR_SEL = 20'h0AA55,
    localparam int K = lc_pkg::LUT_K,
    localparam int W = lc_pkg::LUT_W
) (
    input  logic                clk_a,
    input  logic                clk_b,
    input  logic                rst,
    input  logic                ena_a,
    input  logic                ena_b,
    input  logic                aclr0,
    input  logic                aclr1,
    input  logic                aload,
    input  logic [N_CELL-1:0]   aload_data,
    input  logic                sclr,
    input  logic                sload,
    input  logic                add_sub,
    input  logic                carry_in,
    input  logic                shift_in,
    input  logic [N_CELL*W-1:0] lut_mask,
    input  logic [N_CELL-1:0]   lut_link_en,
    input  logic [N_CELL-1:0]   reg_chain_en,
    input  logic [N_CELL-1:0]   arith_en,
    input  logic [N_CELL*K-1:0] din,
    output logic [N_CELL-1:0]   comb_out,
    output logic [N_CELL-1:0]   reg_out,
    output logic                carry_out
);
    logic [N_CELL-1:0] cell_clk;
    logic [N_CELL-1:0] cell_ce;
    logic [N_CELL-1:0] cell_clr;
    logic [N_CELL-1:0] prev_q;

    assign prev_q = {reg_out[N_CELL-2:0], shift_in};

    lc_ctrl #(.N_CELL(N_CELL), .CLK_SEL(CLK_SEL), .ACLR_SEL(ACLR_SEL)) u_ctrl (
        .clk_a(clk_a), .clk_b(clk_b), .ena_a(ena_a), .ena_b(ena_b),
        .aclr0(aclr0), .aclr1(aclr1),
        .cell_clk(cell_clk), .cell_ce(cell_ce), .cell_clr(cell_clr)
    );

    lc_comb #(.N_CELL(N_CELL)) u_comb (
        .lut_mask(lut_mask), .din(din), .lut_link_en(lut_link_en),
        .arith_en(arith_en), .add_sub(add_sub), .carry_in(carry_in),
        .comb_out(comb_out), .carry_out(carry_out)
    );

    for (genvar i = 0; i < N_CELL; i++) begin : g_reg
        lc_reg u_reg (
            .clk(cell_clk[i]), .rst(rst), .ce(cell_ce[i]), .clr(cell_clr[i]),
            .aload(aload), .aload_val(aload_data[i]),
            .sclr(sclr), .sload(sload), .sload_val(din[i*K + 2]),
            .chain_sel(reg_chain_en[i]), .chain_val(prev_q[i]),
            .data_val(comb_out[i]), .q(reg_out[i])
        );
    end

    // R3: with no arithmetic cell the carry passes straight through
    p_carry_pass_r3: assert property (@(posedge clk_a) disable iff (rst)
        (arith_en == '0) |-> (carry_out == carry_in));
endmodule

// File: tb/test_lcell_cluster.sv
`timescale 1ns/1ps
module test_lcell_cluster;
    localparam int N = 10;
    localparam int K = 4;
    localparam int W = 16;
    localparam logic [N-1:0]   CSEL = 10'b11111_00000;
    localparam logic [2*N-1:0] ASEL = 20'h0AA55;

    logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
    logic ena_a = 1'b1, ena_b = 1'b1, aclr0 = 1'b0, aclr1 = 1'b0, aload = 1'b0;
    logic sclr = 1'b0, sload = 1'b0, add_sub = 1'b1, carry_in = 1'b0, shift_in = 1'b0;
    logic [N-1:0]   aload_data = '0, lut_link_en = '0, reg_chain_en = '0, arith_en = '0;
    logic [N*W-1:0] lut_mask = '0;
    logic [N*K-1:0] din = '0;
    logic [N-1:0]   comb_out, reg_out;
    logic           carry_out;

    logic [N-1:0] q_ref = '0, comb_ref;
    logic         carry_ref;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk_a = ~clk_a;
    initial begin #2.5; clk_b = 1'b1; forever #5 clk_b = ~clk_b; end

    lcell_cluster #(.N_CELL(N), .CLK_SEL(CSEL), .ACLR_SEL(ASEL)) i_lcell_cluster (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .ena_a(ena_a), .ena_b(ena_b),
        .aclr0(aclr0), .aclr1(aclr1), .aload(aload), .aload_data(aload_data),
        .sclr(sclr), .sload(sload), .add_sub(add_sub), .carry_in(carry_in),
        .shift_in(shift_in), .lut_mask(lut_mask), .lut_link_en(lut_link_en),
        .reg_chain_en(reg_chain_en), .arith_en(arith_en), .din(din),
        .comb_out(comb_out), .reg_out(reg_out), .carry_out(carry_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic calc_comb();
        logic [N-1:0] l;
        logic cy;
        cy = carry_in;
        for (int i = 0; i < N; i++) begin
            logic [3:0] s;
            logic bb;
            s = din[i*K +: K];
            if (i > 0 && lut_link_en[i]) s[3] = l[i-1];
            l[i] = lut_mask[i*W + int'(s)];
            if (arith_en[i]) begin
                bb = add_sub ? din[i*K+1] : ~din[i*K+1];
                comb_ref[i] = l[i] ^ bb ^ cy;
                cy = (l[i] & bb) | (l[i] & cy) | (bb & cy);
            end else begin
                comb_ref[i] = l[i];
            end
        end
        carry_ref = cy;
    endtask

    function automatic logic clr_hit(input int i);
        logic [1:0] s;
        s = ASEL[2*i +: 2];
        return (s == 2'b01 && aclr0) || (s == 2'b10 && aclr1);
    endfunction

    task automatic apply_async();
        for (int i = 0; i < N; i++) begin
            if (clr_hit(i)) q_ref[i] = 1'b0;
            else if (aload) q_ref[i] = aload_data[i];
        end
    endtask

    function automatic logic next_bit(input int i, input logic bnext);
        logic tick, en;
        if (clr_hit(i)) return 1'b0;
        if (aload) return aload_data[i];
        tick = CSEL[i] ? bnext : 1'b1;
        en   = CSEL[i] ? ena_b : ena_a;
        if (!tick) return q_ref[i];
        if (rst) return 1'b0;
        if (!en) return q_ref[i];
        if (sclr) return 1'b0;
        if (sload) return din[i*K+2];
        if (reg_chain_en[i]) return (i == 0) ? shift_in : q_ref[i-1];
        return comb_ref[i];
    endfunction

    // called at a clk_a falling edge with inputs already set
    task automatic step(input string tag);
        logic bnext;
        logic [N-1:0] nq;
        bnext = (clk_b == 1'b0);
        calc_comb();
        for (int i = 0; i < N; i++) nq[i] = next_bit(i, bnext);
        @(posedge clk_a);
        @(negedge clk_a);
        q_ref = nq;
        calc_comb();
        chk(tag, 32'(reg_out), 32'(q_ref));
        chk(tag, 32'(comb_out), 32'(comb_ref));
        chk(tag, 32'(carry_out), 32'(carry_ref));
    endtask

    task automatic rand_data();
        for (int i = 0; i < N; i++) lut_mask[i*W +: W] = W'($urandom);
        for (int i = 0; i < N; i++) din[i*K +: K] = K'($urandom);
        add_sub  = 1'($urandom);
        carry_in = 1'($urandom);
        shift_in = 1'($urandom);
    endtask

    task automatic align_b();
        if (clk_b == 1'b1) step("R4");
    endtask

    task automatic mix(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            rand_data();
            lut_link_en  = N'($urandom);
            reg_chain_en = N'($urandom);
            arith_en     = N'($urandom);
            aload_data   = N'($urandom);
            ena_a = ($urandom % 4) != 0;
            ena_b = ($urandom % 4) != 0;
            sclr  = ($urandom % 8) == 0;
            sload = ($urandom % 6) == 0;
            rst   = ($urandom % 50) == 0;
            aclr0 = 1'b0; aclr1 = 1'b0; aload = 1'b0;
            if (clk_b == 1'b0 && ($urandom % 10) == 0) begin
                case ($urandom % 3)
                    0: aclr0 = 1'b1;
                    1: aclr1 = 1'b1;
                    default: aload = 1'b1;
                endcase
                #1;
                apply_async();
                chk("R7", 32'(reg_out), 32'(q_ref));
            end
            step("R5");
        end
        aclr0 = 1'b0; aclr1 = 1'b0; aload = 1'b0; rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk_a);
        // reset
        repeat (4) @(negedge clk_a);
        q_ref = '0;
        chk("R1", 32'(reg_out), 32'h0);
        rst = 1'b0;

        // R2 random truth tables, plain capture (R10)
        for (int c = 0; c < 200; c++) begin
            rand_data();
            lut_link_en = N'($urandom);
            step("R2");
        end
        // R2 directed: every table passes d, link chain throughout
        lut_link_en = '1;
        for (int i = 0; i < N; i++) lut_mask[i*W +: W] = 16'hFF00;
        din = '0; din[3] = 1'b1;
        step("R2");
        chk("R2", 32'(comb_out), 32'h3FF);
        lut_link_en = '0;

        // R3 directed ripple: a all ones, b zero, add with carry in
        arith_en = '1;
        for (int i = 0; i < N; i++) lut_mask[i*W +: W] = 16'hAAAA;
        din = '0;
        for (int i = 0; i < N; i++) din[i*K] = 1'b1;
        add_sub = 1'b1; carry_in = 1'b1;
        step("R3");
        chk("R3", 32'(comb_out), 32'h0);
        chk("R3", 32'(carry_out), 32'h1);
        // subtract: a - 0 with carry in 1 leaves a and carries out
        add_sub = 1'b0;
        step("R3");
        chk("R3", 32'(comb_out), 32'h3FF);
        for (int c = 0; c < 150; c++) begin
            rand_data();
            for (int i = 0; i < N; i++)
                if (c % 2 == 0) lut_mask[i*W +: W] = 16'hAAAA;
            step("R3");
        end
        for (int c = 0; c < 100; c++) begin
            rand_data();
            arith_en = N'($urandom);
            step("R3");
        end
        arith_en = '0;

        // R4/R5: one clock group stopped, other running, sync controls active
        ena_a = 1'b0; ena_b = 1'b1;
        for (int c = 0; c < 40; c++) begin
            rand_data();
            sclr = 1'($urandom); sload = 1'($urandom);
            step("R5");
        end
        ena_a = 1'b1; ena_b = 1'b0;
        for (int c = 0; c < 40; c++) begin
            rand_data();
            sclr = 1'($urandom); sload = 1'($urandom);
            step("R4");
        end
        ena_b = 1'b1;
        // R1: reset works with enables low
        ena_a = 1'b0; ena_b = 1'b0; rst = 1'b1;
        step("R1"); step("R1");
        chk("R1", 32'(reg_out), 32'h0);
        rst = 1'b0; ena_a = 1'b1; ena_b = 1'b1;

        // R8/R9 synchronous clear and load
        for (int c = 0; c < 100; c++) begin
            rand_data();
            sclr = ($urandom % 3) == 0; sload = 1'($urandom);
            step("R8");
        end
        sload = 1'b1; sclr = 1'b0;
        for (int i = 0; i < N; i++) din[i*K+2] = 1'b1;
        step("R9"); step("R9");
        chk("R9", 32'(reg_out), 32'h3FF);
        sclr = 1'b1;
        step("R8"); step("R8");
        chk("R8", 32'(reg_out), 32'h0);
        sclr = 1'b0; sload = 1'b0;

        // R10 register shift chain across both clock groups
        reg_chain_en = '1;
        for (int c = 0; c < 40; c++) begin
            shift_in = 1'($urandom);
            step("R10");
        end
        reg_chain_en = '0;

        // R6 asynchronous clears, seen before any clock edge
        sload = 1'b1; for (int i = 0; i < N; i++) din[i*K+2] = 1'b1;
        step("R9"); step("R9");
        sload = 1'b0; ena_a = 1'b0; ena_b = 1'b0;
        align_b();
        aclr0 = 1'b1; #1; apply_async();
        chk("R6", 32'(reg_out), 32'h3F0);
        step("R6");
        aclr0 = 1'b0; step("R6");
        align_b();
        aclr1 = 1'b1; #1; apply_async();
        chk("R6", 32'(reg_out), 32'h300);
        step("R6");
        aclr1 = 1'b0; step("R6");

        // R7 asynchronous load and preset, clear dominates
        align_b();
        aload_data = 10'h2B5; aload = 1'b1; #1; apply_async();
        chk("R7", 32'(reg_out), 32'h2B5);
        step("R7");
        aload = 1'b0; step("R7");
        align_b();
        aload_data = '1; aload = 1'b1; aclr0 = 1'b1; #1; apply_async();
        chk("R7", 32'(reg_out), 32'h3F0);
        step("R7");
        aload = 1'b0; aclr0 = 1'b0; step("R7");
        ena_a = 1'b1; ena_b = 1'b1;

        // random mix of everything
        mix(1500);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule